// File: doc/BRIEF.md
# Serial Configuration Port for a Dual-Bank Synthesizer

This block is the slave end of a clock/data/enable serial link that programs a frequency synthesizer and its mode controller. A host first toggles the serial clock once with enable high to arm the port. It then drops enable and shifts in a 17-bit frame, most significant bit first. When enable returns high, the port decodes the address at the tail of the frame and loads one of five registers: two 14-bit feedback divide values, two 11-bit reference divide values each paired with a 2-bit pump current code, and a 13-bit mode word.

The serial pins are sampled by the block's fast system clock, and their edges are detected in that domain. The register contents are held at power-on defaults by the reset and by the active-low shutdown pin. A two-level mode pin, with a separate "driven" qualifier that stands for a pin that is not floating, can force three selection bits of the mode word. A one-cycle strobe marks every load of the mode word, so that the acquisition-assist logic can restart.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the outputs are `m1_o`=10519, `m2_o`=4269, `r1_o`=`r2_o`=492, `cp1_o`=`cp2_o`=2'b11, `ctrl_o`=13'h0B57, and `ctrl_wr_o`=0.
- R2: A frame loads nothing unless, since the previous frame, `ser_clk` made a full rise and fall while `ser_en` was high before `ser_en` fell.
- R3: While `ser_en` is low, each rising edge of `ser_clk` shifts in `ser_dat`. Frame bit 16 (the first bit sent) is the start bit. The registers change only in response to a rising edge of `ser_en`.
- R4: When frame bit 1 is 0, the frame is a feedback-divider write. Frame bit 0 = 0 selects `m1_o` and frame bit 0 = 1 selects `m2_o`, and the value loaded is frame bits 15:2.
- R5: Frame bits 2:0 = 3'b010 load `cp1_o` from bits 15:14 and `r1_o` from bits 13:3. Frame bits 2:0 = 3'b011 load `cp2_o` and `r2_o` from the same fields.
- R6: Frame bits 2:0 = 3'b110 load the mode word from bits 15:3. In the mode word, bit 8 is the bank select, bit 6 is the oscillator select and bit 2 is the input select.
- R7: A frame whose start bit is 0, including any frame shorter than 17 bits, changes no register and raises no strobe.
- R8: A frame with address 3'b111 changes no register and raises no strobe.
- R9: While `mode_drv` is 1, `ctrl_o` bits 8, 6 and 2 equal `mode_lvl` and the stored bits are unaffected. While `mode_drv` is 0, `ctrl_o` shows the stored word.
- R10: `ctrl_wr_o` is high for exactly one cycle for each mode-word load, and never for any other load.
- R11: While `shdn_n` is low, every register returns to its R1 default. A mode word with bit 0 (the soft power-down bit) cleared leaves the port fully able to accept later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| shdn_n | input | 1 | Shutdown pin, active low; restores defaults |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Frame enable; low while shifting, rising edge loads |
| mode_drv | input | 1 | 1 when the mode pin is driven, 0 when it floats |
| mode_lvl | input | 1 | Level of the driven mode pin |
| m1_o | output | 14 | Bank 1 feedback divide value |
| m2_o | output | 14 | Bank 2 feedback divide value |
| r1_o | output | 11 | Bank 1 reference divide value |
| r2_o | output | 11 | Bank 2 reference divide value |
| cp1_o | output | 2 | Bank 1 pump current code |
| cp2_o | output | 2 | Bank 2 pump current code |
| ctrl_o | output | 13 | Mode word after pin overrides |
| ctrl_wr_o | output | 1 | One-cycle pulse when the mode word loads |

## Verification
On every cycle, the assertions check the following rules:
- the divide and pump registers hold still unless an enable rise has been decoded;
- shutdown forces every default;
- the strobe lasts one cycle and follows only a decoded enable rise whose frame had its start bit set;
- a floating mode pin leaves the mode word unchanged between writes.

Only the directed scenarios can show the field placement of each address, the arming rule, the rejection of short frames and of address 111, and the exact values forced by the mode pin.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int M_W    = 14,
  parameter int R_W    = 11,
  parameter int CP_W   = 2,
  parameter int CTRL_W = 13,
  parameter logic [M_W-1:0]    M1_DEF   = 14'd10519,
  parameter logic [M_W-1:0]    M2_DEF   = 14'd4269,
  parameter logic [R_W-1:0]    R_DEF    = 11'd492,
  parameter logic [CP_W-1:0]   CP_DEF   = 2'b11,
  parameter logic [CTRL_W-1:0] CTRL_DEF = 13'h0B57,
  parameter int DS_BIT = 8,
  parameter int VS_BIT = 6,
  parameter int IS_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  input  logic              mode_drv,
  input  logic              mode_lvl,
  output logic [M_W-1:0]    m1_o,
  output logic [M_W-1:0]    m2_o,
  output logic [R_W-1:0]    r1_o,
  output logic [R_W-1:0]    r2_o,
  output logic [CP_W-1:0]   cp1_o,
  output logic [CP_W-1:0]   cp2_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_wr_o
);
  localparam int FW = M_W + 3;
  localparam int LW = FW - 4;

  logic sclk_q, sclk_d, sen_q, sen_d, dat_q;
  logic init_seen, armed, active;
  logic [FW-1:0] sr;
  logic [CTRL_W-1:0] ctrl_q;

  wire sclk_rise = sclk_q & ~sclk_d;
  wire sclk_fall = ~sclk_q & sclk_d;
  wire en_rise   = sen_q & ~sen_d;
  wire en_fall   = ~sen_q & sen_d;

  wire            load_ok = en_rise & active & sr[FW-1];
  wire [M_W-1:0]  m_val   = sr[FW-2:2];
  wire [LW-1:0]   l_val   = sr[FW-2:3];
  wire hit_m1 = load_ok & ~sr[1] & ~sr[0];
  wire hit_m2 = load_ok & ~sr[1] &  sr[0];
  wire hit_r1 = load_ok & (sr[2:0] == 3'b010);
  wire hit_r2 = load_ok & (sr[2:0] == 3'b011);
  wire hit_c  = load_ok & (sr[2:0] == 3'b110);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sclk_d <= 1'b0;
      sen_q  <= 1'b1; sen_d  <= 1'b1;
      dat_q  <= 1'b0;
    end else begin
      sclk_q <= ser_clk; sclk_d <= sclk_q;
      sen_q  <= ser_en;  sen_d  <= sen_q;
      dat_q  <= ser_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_seen <= 1'b0; armed <= 1'b0; active <= 1'b0; sr <= '0;
    end else if (!shdn_n) begin
      init_seen <= 1'b0; armed <= 1'b0; active <= 1'b0; sr <= '0;
    end else if (en_fall) begin
      active    <= armed;
      armed     <= 1'b0;
      init_seen <= 1'b0;
      sr        <= '0;
    end else if (en_rise) begin
      active <= 1'b0;
    end else if (sen_q) begin
      if (sclk_rise) init_seen <= 1'b1;
      if (sclk_fall && init_seen) armed <= 1'b1;
    end else if (active && sclk_rise) begin
      sr <= {sr[FW-2:0], dat_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_o <= M1_DEF; m2_o <= M2_DEF; r1_o <= R_DEF; r2_o <= R_DEF;
      cp1_o <= CP_DEF; cp2_o <= CP_DEF; ctrl_q <= CTRL_DEF; ctrl_wr_o <= 1'b0;
    end else if (!shdn_n) begin
      m1_o <= M1_DEF; m2_o <= M2_DEF; r1_o <= R_DEF; r2_o <= R_DEF;
      cp1_o <= CP_DEF; cp2_o <= CP_DEF; ctrl_q <= CTRL_DEF; ctrl_wr_o <= 1'b0;
    end else begin
      if (hit_m1) m1_o <= m_val;
      if (hit_m2) m2_o <= m_val;
      if (hit_r1) {cp1_o, r1_o} <= l_val;
      if (hit_r2) {cp2_o, r2_o} <= l_val;
      if (hit_c)  ctrl_q <= l_val;
      ctrl_wr_o <= hit_c;
    end
  end

  always_comb begin
    ctrl_o = ctrl_q;
    if (mode_drv) begin
      ctrl_o[DS_BIT] = mode_lvl;
      ctrl_o[VS_BIT] = mode_lvl;
      ctrl_o[IS_BIT] = mode_lvl;
    end
  end
endmodule

module serial_reg_port_chk #(
  parameter int M_W = 14, parameter int R_W = 11, parameter int CP_W = 2, parameter int CTRL_W = 13,
  parameter logic [M_W-1:0]    M1_DEF   = 14'd10519,
  parameter logic [M_W-1:0]    M2_DEF   = 14'd4269,
  parameter logic [R_W-1:0]    R_DEF    = 11'd492,
  parameter logic [CP_W-1:0]   CP_DEF   = 2'b11,
  parameter logic [CTRL_W-1:0] CTRL_DEF = 13'h0B57
) (
  input logic clk, rst_n, shdn_n, mode_drv, en_rise, start_bit, ctrl_wr_o,
  input logic [M_W-1:0] m1_o, m2_o,
  input logic [R_W-1:0] r1_o, r2_o,
  input logic [CP_W-1:0] cp1_o, cp2_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n && !en_rise) |=> ($stable(m1_o) && $stable(m2_o) && $stable(r1_o) &&
                              $stable(r2_o) && $stable(cp1_o) && $stable(cp2_o))); // R3
  AST_SHDN_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (m1_o == M1_DEF && m2_o == M2_DEF && r1_o == R_DEF && r2_o == R_DEF &&
                 cp1_o == CP_DEF && cp2_o == CP_DEF && !ctrl_wr_o)); // R11
  AST_WR_AFTER_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |-> $past(en_rise)); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> !ctrl_wr_o); // R10
  AST_WR_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |-> $past(start_bit)); // R7
  AST_CTRL_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_drv && $stable(mode_drv) && !ctrl_wr_o && $past(shdn_n)) |-> $stable(ctrl_o)); // R9
endmodule

bind serial_reg_port serial_reg_port_chk #(
  .M_W(M_W), .R_W(R_W), .CP_W(CP_W), .CTRL_W(CTRL_W),
  .M1_DEF(M1_DEF), .M2_DEF(M2_DEF), .R_DEF(R_DEF), .CP_DEF(CP_DEF), .CTRL_DEF(CTRL_DEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mode_drv(mode_drv), .en_rise(en_rise),
  .start_bit(sr[FW-1]), .ctrl_wr_o(ctrl_wr_o), .m1_o(m1_o), .m2_o(m2_o), .r1_o(r1_o),
  .r2_o(r2_o), .cp1_o(cp1_o), .cp2_o(cp2_o), .ctrl_o(ctrl_o)
);

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0, shdn_n = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
  logic mode_drv = 1'b0, mode_lvl = 1'b0;
  logic [13:0] m1_o, m2_o;
  logic [10:0] r1_o, r2_o;
  logic [1:0]  cp1_o, cp2_o;
  logic [12:0] ctrl_o;
  logic        ctrl_wr_o;
  int n_run = 0, n_fail = 0, wr_hi = 0;

  always #2 clk = ~clk;

  serial_reg_port dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en(ser_en), .mode_drv(mode_drv), .mode_lvl(mode_lvl), .m1_o(m1_o), .m2_o(m2_o),
    .r1_o(r1_o), .r2_o(r2_o), .cp1_o(cp1_o), .cp2_o(cp2_o), .ctrl_o(ctrl_o), .ctrl_wr_o(ctrl_wr_o)
  );

  always @(negedge clk) if (ctrl_wr_o) wr_hi++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [16:0] mk2(input logic a0, input logic [13:0] v);
    return {1'b1, v, 1'b0, a0};
  endfunction

  function automatic logic [16:0] mk3(input logic [2:0] a, input logic [12:0] v);
    return {1'b1, v, a};
  endfunction

  task automatic send(input logic [16:0] f, input int n, input bit init);
    ser_en = 1'b1; idle(4);
    if (init) begin
      ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4);
    end
    ser_en = 1'b0; idle(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = f[i]; idle(4);
      ser_clk = 1'b1; idle(4);
      ser_clk = 1'b0; idle(2);
    end
    ser_en = 1'b1; idle(8);
  endtask

  task automatic t_reset;
    check("R1 m1", m1_o, 10519);  check("R1 m2", m2_o, 4269);
    check("R1 r1", r1_o, 492);    check("R1 r2", r2_o, 492);
    check("R1 cp", {cp1_o, cp2_o}, 4'b1111);
    check("R1 ctrl", ctrl_o, 13'h0B57);
    check("R1 strobe", wr_hi, 0);
  endtask

  task automatic t_div;
    int w0 = wr_hi;
    send(mk2(1'b0, 14'h2AAA), 17, 1'b1);
    check("R4 m1 load", m1_o, 14'h2AAA);
    check("R4 m2 untouched", m2_o, 4269);
    send(mk2(1'b1, 14'h1555), 17, 1'b1);
    check("R4 m2 load", m2_o, 14'h1555);
    check("R3 m1 kept", m1_o, 14'h2AAA);
    check("R10 no strobe on divider", wr_hi, w0);
  endtask

  task automatic t_ref;
    send(mk3(3'b010, {2'b01, 11'h5A5}), 17, 1'b1);
    check("R5 r1", r1_o, 11'h5A5); check("R5 cp1", cp1_o, 2'b01);
    check("R5 r2 untouched", r2_o, 492);
    send(mk3(3'b011, {2'b10, 11'h7FF}), 17, 1'b1);
    check("R5 r2", r2_o, 11'h7FF); check("R5 cp2", cp2_o, 2'b10);
    check("R5 cp1 kept", cp1_o, 2'b01);
  endtask

  task automatic t_ctrl;
    int w0 = wr_hi;
    send(mk3(3'b110, 13'h1234), 17, 1'b1);
    check("R6 ctrl", ctrl_o, 13'h1234);
    check("R10 one strobe cycle", wr_hi, w0 + 1);
  endtask

  task automatic t_no_init;
    send(mk2(1'b0, 14'h0123), 17, 1'b0);
    check("R2 unarmed frame ignored", m1_o, 14'h2AAA);
  endtask

  task automatic t_bad_frames;
    int w0 = wr_hi;
    send({1'b0, 13'h0AAA, 3'b110}, 17, 1'b1);
    check("R7 zero start ignored", ctrl_o, 13'h1234);
    send(mk2(1'b0, 14'h0F0F) >> 1, 16, 1'b1);
    check("R7 short frame m1", m1_o, 14'h2AAA);
    check("R7 short frame m2", m2_o, 14'h1555);
    send(mk3(3'b111, 13'h0FFF), 17, 1'b1);
    check("R8 addr 111 ctrl", ctrl_o, 13'h1234);
    check("R8 addr 111 r1", r1_o, 11'h5A5);
    check("R8 no strobe", wr_hi, w0);
  endtask

  task automatic t_mode;
    send(mk3(3'b110, 13'h0000), 17, 1'b1);
    send(mk2(1'b0, 14'h0007), 17, 1'b1);
    check("R11 port alive after soft power-down", m1_o, 14'h0007);
    mode_drv = 1'b1; mode_lvl = 1'b1; idle(2);
    check("R9 force high", ctrl_o, 13'h0144);
    send(mk3(3'b110, 13'h1FFF), 17, 1'b1);
    mode_lvl = 1'b0; idle(2);
    check("R9 force low", ctrl_o, 13'h1EBB);
    mode_drv = 1'b0; idle(2);
    check("R9 float shows stored", ctrl_o, 13'h1FFF);
  endtask

  task automatic t_shdn;
    int w0 = wr_hi;
    shdn_n = 1'b0; idle(4); shdn_n = 1'b1; idle(2);
    check("R11 m1 default", m1_o, 10519);
    check("R11 r2 default", r2_o, 492);
    check("R11 cp2 default", cp2_o, 2'b11);
    check("R11 ctrl default", ctrl_o, 13'h0B57);
    check("R11 no strobe", wr_hi, w0);
  endtask

  initial begin
    idle(5); rst_n = 1'b1; idle(5);
    t_reset;
    t_div;
    t_ref;
    t_ctrl;
    t_no_init;
    t_bad_frames;
    t_mode;
    t_shdn;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule